// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Core

This block is a small processor built around one accumulator. Every instruction passes through two stages. In the fetch stage, the word addressed by the program counter goes through the memory address and memory buffer registers into the instruction register, and the program counter advances by one. In the execute stage, the instruction register is decoded, and any operand traffic again goes through the memory address and buffer registers. The instruction word is 16 bits. The upper 4 bits select the operation and the lower 12 bits name a word in a 4096-word memory.

The core drives one external synchronous memory port. The memory returns read data one cycle after the address is presented and performs a write on the clock edge at the end of a write-enable cycle. This port has a fixed timing contract instead of a valid/ready handshake. The memory cannot apply back-pressure, and the core never stalls an issued access. A reset starts execution at the address on `start_addr`. A halt instruction stops the core, so a program can signal that it has finished.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `acc` reads 0, `pc` equals `start_addr`, `halted` is 0 and `mem_we` is 0.
- R2: Instructions are fetched from consecutive addresses. `pc` advances by exactly one per fetched instruction and wraps from 0xFFF to 0x000.
- R3: Bits [15:12] of an instruction word select the operation. Bits [11:0] give the full 12-bit operand address.
- R4: Opcode 0x1 replaces the accumulator with the memory word at the operand address.
- R5: Opcode 0x5 adds the memory word at the operand address to the accumulator, modulo 2^16.
- R6: Opcode 0x2 writes the accumulator to the operand address in a single one-cycle `mem_we` pulse. The word is visible to the very next instruction fetch.
- R7: Opcode 0xF raises `halted`. After that, `halted` stays high, `pc` and `acc` stay constant and no memory write occurs until reset.
- R8: Any other opcode is a no-op. The accumulator and memory are unchanged and `pc` still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 12 | Address of the first instruction, loaded into the PC during reset |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_we | output | 1 | Write strobe for one cycle |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |
| acc | output | 16 | Current accumulator value |
| pc | output | 12 | Current program counter |

## Verification
In the store cycle, the core writes the accumulator to memory and, in that same cycle, loads the address register with the PC for the next fetch. The next fetch therefore reads memory immediately behind the write. The bench provokes this overlap with a program that stores over the instruction that follows the store. It judges the result by which instruction actually runs: a halt leaves the PC one past the overwritten word, while the original add would change the accumulator and run on.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;
  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_LOAD  = 4'h1;
  localparam opc_t OPC_STORE = 4'h2;
  localparam opc_t OPC_ADD   = 4'h5;
  localparam opc_t OPC_HALT  = 4'hF;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3,
    S_E0, S_E1, S_E2, S_E3,
    S_ST, S_HALT
  } state_t;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic ir_load;
    logic pc_inc;
    logic ac_load;
    logic ac_add;
    logic mem_we;
  } ctl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  opc_t opcode,
  output ctl_t ctl,
  output logic halted
);
  state_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_F0;
    else        st <= st_nx;
  end

  always_comb begin
    ctl   = '0;
    st_nx = st;
    unique case (st)
      S_F0: begin ctl.mar_from_pc = 1'b1; st_nx = S_F1; end
      S_F1: st_nx = S_F2;                       // read latency
      S_F2: begin ctl.mbr_from_mem = 1'b1; st_nx = S_F3; end
      S_F3: begin ctl.ir_load = 1'b1; ctl.pc_inc = 1'b1; st_nx = S_E0; end
      S_E0: begin
        unique case (opcode)
          OPC_LOAD, OPC_ADD: begin ctl.mar_from_ir = 1'b1; st_nx = S_E1; end
          OPC_STORE: begin
            ctl.mar_from_ir = 1'b1;
            ctl.mbr_from_ac = 1'b1;
            st_nx = S_ST;
          end
          OPC_HALT: st_nx = S_HALT;
          default:  st_nx = S_F0;               // no-op
        endcase
      end
      S_E1: st_nx = S_E2;                       // operand latency
      S_E2: begin ctl.mbr_from_mem = 1'b1; st_nx = S_E3; end
      S_E3: begin
        ctl.ac_load     = 1'b1;
        ctl.ac_add      = (opcode == OPC_ADD);
        ctl.mar_from_pc = 1'b1;                 // overlap next fetch address
        st_nx = S_F1;
      end
      S_ST: begin
        ctl.mem_we      = 1'b1;
        ctl.mar_from_pc = 1'b1;                 // write and fetch setup share a cycle
        st_nx = S_F1;
      end
      S_HALT: st_nx = S_HALT;
      default: st_nx = S_F0;
    endcase
  end

  assign halted = (st == S_HALT);

  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_idle_when_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (ctl == '0));
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] operand,
  input  logic              add_sel,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    if (add_sel) y = ac + operand;   // wraps modulo 2^DATA_W
    else         y = operand;
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_y,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] ac
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= start_addr;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (ctl.pc_inc)            pc  <= pc + PC_STEP;
      if (ctl.mar_from_pc)       mar <= pc;
      else if (ctl.mar_from_ir)  mar <= ir[ADDR_W-1:0];
      if (ctl.mbr_from_mem)      mbr <= mem_rdata;
      else if (ctl.mbr_from_ac)  mbr <= ac;
      if (ctl.ir_load)           ir  <= mbr;
      if (ctl.ac_load)           ac  <= alu_y;
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == $past(pc) + PC_STEP));
  p_ac_only_on_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ac != $past(ac)) |-> $past(ctl.ac_load));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);
  localparam int OP_LSB = DATA_W - OPC_W;

  ctl_t              ctl;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr, ir, ac_q, alu_y;

  acc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (ir[DATA_W-1:OP_LSB]),
    .ctl    (ctl),
    .halted (halted)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .ac      (ac_q),
    .operand (mbr),
    .add_sel (ctl.ac_add),
    .y       (alu_y)
  );

  acc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_addr (start_addr),
    .ctl        (ctl),
    .mem_rdata  (mem_rdata),
    .alu_y      (alu_y),
    .pc         (pc),
    .mar        (mar),
    .mbr        (mbr),
    .ir         (ir),
    .ac         (ac_q)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = ctl.mem_we;
  assign acc       = ac_q;

  p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_store_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc));
  p_pc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc) && $stable(acc));
  p_no_write_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] start_addr = 12'h000;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        halted;
  logic [15:0] acc;
  logic [11:0] pc;

  logic [15:0] mem [0:4095];
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .halted(halted), .acc(acc), .pc(pc)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic start(input logic [11:0] sa);
    @(negedge clk);
    rst_n = 1'b0;
    start_addr = sa;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 no halt: actual running expected halted");
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_addr = 12'h300;
    repeat (2) @(negedge clk);
    check("R1", "pc in reset", 32'(pc), 32'h300);
    check("R1", "acc in reset", 32'(acc), 32'h0);
    check("R1", "halted in reset", 32'(halted), 32'h0);
    check("R1", "we in reset", 32'(mem_we), 32'h0);
  endtask

  task automatic t_example();
    clear_mem();
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
    mem[12'h302] = 16'h2941; mem[12'h303] = 16'hF000;
    mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
    start(12'h300);
    run_to_halt();
    check("R6", "stored sum", 32'(mem[12'h941]), 32'h5);
    check("R5", "acc after add", 32'(acc), 32'h5);
    check("R4", "load source intact", 32'(mem[12'h940]), 32'h3);
    check("R2", "pc past halt", 32'(pc), 32'h304);
  endtask

  task automatic t_add_wrap();
    clear_mem();
    mem[12'h010] = 16'h1080; mem[12'h011] = 16'h5081;
    mem[12'h012] = 16'h2082; mem[12'h013] = 16'hF000;
    mem[12'h080] = 16'hFFFF; mem[12'h081] = 16'h0003;
    start(12'h010);
    run_to_halt();
    check("R5", "wrapped sum acc", 32'(acc), 32'h0002);
    check("R6", "wrapped sum mem", 32'(mem[12'h082]), 32'h0002);
  endtask

  task automatic t_addr_field();
    clear_mem();
    mem[12'h600] = 16'h1ABC; mem[12'h601] = 16'h2FFE;
    mem[12'h602] = 16'hF000; mem[12'hABC] = 16'h5A5A;
    start(12'h600);
    run_to_halt();
    check("R3", "full address load/store", 32'(mem[12'hFFE]), 32'h5A5A);
    check("R4", "acc loaded", 32'(acc), 32'h5A5A);
  endtask

  task automatic t_noop();
    clear_mem();
    mem[12'h400] = 16'h1500; mem[12'h401] = 16'h3501;
    mem[12'h402] = 16'h0502; mem[12'h403] = 16'hE503;
    mem[12'h404] = 16'hF000;
    mem[12'h500] = 16'h00AA; mem[12'h501] = 16'h1111;
    mem[12'h502] = 16'h2222; mem[12'h503] = 16'h3333;
    start(12'h400);
    run_to_halt();
    check("R8", "acc unchanged by no-ops", 32'(acc), 32'h00AA);
    check("R8", "mem 501", 32'(mem[12'h501]), 32'h1111);
    check("R8", "mem 502", 32'(mem[12'h502]), 32'h2222);
    check("R8", "mem 503", 32'(mem[12'h503]), 32'h3333);
    check("R8", "pc advanced", 32'(pc), 32'h405);
  endtask

  // store over the next instruction: write and next fetch are back to back
  task automatic t_selfmod();
    clear_mem();
    mem[12'h100] = 16'h1200; mem[12'h101] = 16'h2102;
    mem[12'h102] = 16'h5201; mem[12'h103] = 16'hF000;
    mem[12'h200] = 16'hF000; mem[12'h201] = 16'h0007;
    start(12'h100);
    run_to_halt();
    check("R6", "overwritten word", 32'(mem[12'h102]), 32'hF000);
    check("R6", "new word executed pc", 32'(pc), 32'h103);
    check("R6", "new word executed acc", 32'(acc), 32'hF000);
  endtask

  task automatic t_halt_freeze();
    logic [11:0] pc0 = pc;
    logic [15:0] ac0 = acc;
    int writes = 0;
    int drops  = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_we) writes++;
      if (!halted) drops++;
    end
    check("R7", "pc frozen", 32'(pc), 32'(pc0));
    check("R7", "acc frozen", 32'(acc), 32'(ac0));
    check("R7", "writes while halted", 32'(writes), 32'h0);
    check("R7", "halted dropped", 32'(drops), 32'h0);
  endtask

  task automatic t_pc_wrap();
    clear_mem();
    mem[12'hFFF] = 16'h1010; mem[12'h000] = 16'hF000;
    mem[12'h010] = 16'h1234;
    start(12'hFFF);
    run_to_halt();
    check("R2", "pc wrapped", 32'(pc), 32'h001);
    check("R2", "fetch after wrap", 32'(acc), 32'h1234);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    t_reset();
    t_example();
    t_add_wrap();
    t_addr_field();
    t_noop();
    t_selfmod();
    t_halt_freeze();
    t_pc_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule